// File: doc/BRIEF.md
# Register-to-Register Integer Execute Unit

This block is the purely combinational execute stage for register-to-register integer instructions. It receives two 32-bit operands, a six-bit function code and a five-bit shift count. It returns a 32-bit result and a flag that reports signed overflow. The function code alone picks the operation. The operations are two's-complement add and subtract, four bitwise operations (AND, OR, exclusive OR, inverted OR) and three shifts whose distance is taken from the shift count: left with zero fill, right with zero fill, and right with sign fill.

The result depends only on the current inputs and needs no clock. A pipeline places it between its operand latches and its result latch. The shifts act on the second operand, and the first operand has no effect on them. Any function code that has no assigned operation gives a zero result and a clear flag.

Top module: `alu_rtype_exec`

## Requirements
- R1: Function code 0x20 gives op_a + op_b modulo 2^32. Unsigned carry-out is discarded, so 0xFFFFFFFF + 1 gives 0 with no overflow.
- R2: Function code 0x22 gives op_a - op_b modulo 2^32.
- R3: For 0x20, overflow is 1 exactly when the true signed sum lies outside [-2^31, 2^31-1]. Examples: 0x7FFFFFFF + 1 and 0x80000000 + 0xFFFFFFFB both overflow.
- R4: For 0x22, overflow is 1 exactly when the true signed difference is out of range. This includes 0 - 0x80000000, because the most negative value cannot be negated.
- R5: Function code 0x24 gives op_a & op_b. Function code 0x25 gives op_a | op_b.
- R6: Function code 0x27 gives ~(op_a | op_b). Function code 0x26 gives op_a ^ op_b.
- R7: Function code 0x00 gives op_b shifted left by shamt with zeros entering at bit 0. op_a has no effect.
- R8: Function code 0x02 gives op_b shifted right by shamt with zeros entering at bit 31.
- R9: Function code 0x03 gives op_b shifted right by shamt with copies of bit 31 entering. For example, 0xFFFFFFFA shifted by 1 gives 0xFFFFFFFD.
- R10: shamt covers 0 to 31. A count of 0 passes op_b through unchanged. The value of shamt has no effect on any non-shift operation.
- R11: The overflow flag is 0 for all bitwise and shift operations, whatever the operands are.
- R12: Every function code outside {0x00, 0x02, 0x03, 0x20, 0x22, 0x24, 0x25, 0x26, 0x27} gives a result of 0 and an overflow of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand, and the value that the shifts act on |
| func_code | input | 6 | Operation select |
| shamt | input | 5 | Shift distance |
| result | output | 32 | Operation result |
| overflow | output | 1 | Signed overflow for add and subtract |

## Verification
The unit has no registers, so both result and overflow are due in the same cycle as the inputs that produce them, with zero cycles of latency. The bench drives new inputs just after a rising edge. It compares both outputs against its own model at the following falling edge. This leaves half a period for the inputs to settle and keeps the sampling away from the edge where stimulus changes. Directed corner vectors come first, followed by a long run of random vectors that covers all 64 function codes, and each vector is checked in the cycle where it is applied.

// File: rtl/alu_rtype_pkg.sv
package alu_rtype_pkg;

    localparam int FUNC_W = 6;

    typedef enum logic [FUNC_W-1:0] {
        FN_SLL = 6'h00,
        FN_SRL = 6'h02,
        FN_SRA = 6'h03,
        FN_ADD = 6'h20,
        FN_SUB = 6'h22,
        FN_AND = 6'h24,
        FN_OR  = 6'h25,
        FN_XOR = 6'h26,
        FN_NOR = 6'h27
    } alu_func_e;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_ARITH = 2'd1,
        CLS_LOGIC = 2'd2,
        CLS_SHIFT = 2'd3
    } op_class_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_NOR = 2'd3
    } logic_sel_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RZERO = 2'd1,
        SH_RSIGN = 2'd2
    } shift_sel_e;

    typedef struct packed {
        op_class_e  cls;
        logic       sub;
        logic_sel_e lsel;
        shift_sel_e ssel;
    } alu_ctrl_t;

    function automatic alu_ctrl_t decode_func(input logic [FUNC_W-1:0] f);
        alu_ctrl_t c;
        c = '{cls: CLS_NONE, sub: 1'b0, lsel: LG_AND, ssel: SH_LEFT};
        case (f)
            FN_ADD: c.cls = CLS_ARITH;
            FN_SUB: begin c.cls = CLS_ARITH; c.sub = 1'b1; end
            FN_AND: begin c.cls = CLS_LOGIC; c.lsel = LG_AND; end
            FN_OR:  begin c.cls = CLS_LOGIC; c.lsel = LG_OR;  end
            FN_XOR: begin c.cls = CLS_LOGIC; c.lsel = LG_XOR; end
            FN_NOR: begin c.cls = CLS_LOGIC; c.lsel = LG_NOR; end
            FN_SLL: begin c.cls = CLS_SHIFT; c.ssel = SH_LEFT;  end
            FN_SRL: begin c.cls = CLS_SHIFT; c.ssel = SH_RZERO; end
            FN_SRA: begin c.cls = CLS_SHIFT; c.ssel = SH_RSIGN; end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              sub_en,
    output logic [DATA_W-1:0] sum_out,
    output logic              ovf_out
);
    logic [DATA_W-1:0] b_eff;

    always_comb begin
        b_eff   = sub_en ? ~b_in : b_in;
        sum_out = a_in + b_eff + {{(DATA_W-1){1'b0}}, sub_en};
        ovf_out = (a_in[DATA_W-1] == b_eff[DATA_W-1]) &&
                  (sum_out[DATA_W-1] != a_in[DATA_W-1]);
    end

    // Widened signed reference used only by the checks below
    logic signed [DATA_W:0] wide_res;
    always_comb begin
        wide_res = sub_en
            ? ($signed({a_in[DATA_W-1], a_in}) - $signed({b_in[DATA_W-1], b_in}))
            : ($signed({a_in[DATA_W-1], a_in}) + $signed({b_in[DATA_W-1], b_in}));
        AST_SUM_WRAPS: assert (sum_out == wide_res[DATA_W-1:0]); // R1 R2
        AST_OVF_RANGE: assert (ovf_out == (wide_res[DATA_W] != wide_res[DATA_W-1])); // R3 R4
    end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import alu_rtype_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic_sel_e        sel,
    output logic [DATA_W-1:0] res_out
);
    logic [DATA_W-1:0] or_v;

    always_comb begin
        or_v = a_in | b_in;
        unique case (sel)
            LG_AND:  res_out = a_in & b_in;
            LG_OR:   res_out = or_v;
            LG_XOR:  res_out = a_in ^ b_in;
            default: res_out = ~or_v;
        endcase
    end

    always_comb begin
        if (sel == LG_NOR) begin
            AST_NOR_DISJOINT: assert ((res_out & (a_in | b_in)) == '0); // R6
        end
        if (sel == LG_AND) begin
            AST_AND_SUBSET: assert ((res_out & ~a_in) == '0 && (res_out & ~b_in) == '0); // R5
        end
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
    import alu_rtype_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]  b_in,
    input  logic [SHAMT_W-1:0] amt,
    input  shift_sel_e         sel,
    output logic [DATA_W-1:0]  res_out
);
    logic              go_left;
    logic              fill;
    logic [DATA_W-1:0] core_in;
    logic [DATA_W-1:0] stg [SHAMT_W+1];

    always_comb begin
        go_left = (sel == SH_LEFT);
        fill    = (sel == SH_RSIGN) & b_in[DATA_W-1];
        for (int k = 0; k < DATA_W; k++) begin
            core_in[k] = go_left ? b_in[DATA_W-1-k] : b_in[k];
        end
        stg[0] = core_in;
    end

    // Log-depth right shifter; left shifts reuse it via bit reversal
    for (genvar i = 0; i < SHAMT_W; i++) begin : g_stage
        localparam int STEP = 1 << i;
        always_comb begin
            stg[i+1] = amt[i] ? {{STEP{fill}}, stg[i][DATA_W-1:STEP]} : stg[i];
        end
    end

    always_comb begin
        for (int k = 0; k < DATA_W; k++) begin
            res_out[k] = go_left ? stg[SHAMT_W][DATA_W-1-k] : stg[SHAMT_W][k];
        end
    end

    always_comb begin
        if (amt == '0) begin
            AST_ZERO_AMT_PASS: assert (res_out == b_in); // R10
        end else begin
            if (sel == SH_RSIGN) begin
                AST_SRA_SIGN_KEPT: assert (res_out[DATA_W-1] == b_in[DATA_W-1]); // R9
            end
            if (sel == SH_RZERO) begin
                AST_SRL_TOP_ZERO: assert (res_out[DATA_W-1] == 1'b0); // R8
            end
            if (sel == SH_LEFT) begin
                AST_SLL_LSB_ZERO: assert (res_out[0] == 1'b0); // R7
            end
        end
    end
endmodule

// File: rtl/alu_rtype_exec.sv
module alu_rtype_exec
    import alu_rtype_pkg::*;
#(
    parameter  int DATA_W  = 32,
    localparam int SHAMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]  op_a,
    input  logic [DATA_W-1:0]  op_b,
    input  logic [FUNC_W-1:0]  func_code,
    input  logic [SHAMT_W-1:0] shamt,
    output logic [DATA_W-1:0]  result,
    output logic               overflow
);
    alu_ctrl_t         ctrl;
    logic [DATA_W-1:0] arith_res;
    logic              arith_ovf;
    logic [DATA_W-1:0] logic_res;
    logic [DATA_W-1:0] shift_res;

    always_comb ctrl = decode_func(func_code);

    alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a_in    (op_a),
        .b_in    (op_b),
        .sub_en  (ctrl.sub),
        .sum_out (arith_res),
        .ovf_out (arith_ovf)
    );

    alu_bitwise #(.DATA_W(DATA_W)) u_bitwise (
        .a_in    (op_a),
        .b_in    (op_b),
        .sel     (ctrl.lsel),
        .res_out (logic_res)
    );

    alu_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shifter (
        .b_in    (op_b),
        .amt     (shamt),
        .sel     (ctrl.ssel),
        .res_out (shift_res)
    );

    always_comb begin
        unique case (ctrl.cls)
            CLS_ARITH: result = arith_res;
            CLS_LOGIC: result = logic_res;
            CLS_SHIFT: result = shift_res;
            default:   result = '0;
        endcase
        overflow = (ctrl.cls == CLS_ARITH) & arith_ovf;
    end

    always_comb begin
        if (func_code != FN_ADD && func_code != FN_SUB) begin
            AST_NO_OVERFLOW: assert (!overflow); // R11
        end
        if (ctrl.cls == CLS_NONE) begin
            AST_UNKNOWN_ZERO: assert (result == '0); // R12
        end
    end
endmodule

// File: tb/alu_rtype_exec_tb.sv
`timescale 1ns/1ps
module alu_rtype_exec_tb_top;

    typedef struct {
        logic [31:0] a;
        logic [31:0] b;
        logic [5:0]  f;
        logic [4:0]  sh;
        string       tag;
    } vec_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [5:0]  func_code = '0;
    logic [4:0]  shamt = '0;
    logic [31:0] result;
    logic        overflow;

    int total = 0;
    int bad   = 0;
    vec_t vq[$];

    always #2.5 clk = ~clk;

    alu_rtype_exec dut_i (
        .op_a      (op_a),
        .op_b      (op_b),
        .func_code (func_code),
        .shamt     (shamt),
        .result    (result),
        .overflow  (overflow)
    );

    // Behavioural reference built from the requirement list
    task automatic model(input logic [31:0] a, input logic [31:0] b,
                         input logic [5:0] f, input logic [4:0] sh,
                         output logic [31:0] r, output logic o);
        longint exact;
        logic signed [31:0] sb;
        r = '0; o = 1'b0;
        sb = b;
        case (f)
            6'h20: begin
                exact = longint'($signed(a)) + longint'($signed(b));
                r = a + b;
                o = (exact > 64'sd2147483647) || (exact < -64'sd2147483648);
            end
            6'h22: begin
                exact = longint'($signed(a)) - longint'($signed(b));
                r = a - b;
                o = (exact > 64'sd2147483647) || (exact < -64'sd2147483648);
            end
            6'h24: r = a & b;
            6'h25: r = a | b;
            6'h26: r = a ^ b;
            6'h27: r = ~(a | b);
            6'h00: r = b << sh;
            6'h02: r = b >> sh;
            6'h03: r = sb >>> sh;
            default: ;
        endcase
    endtask

    function automatic string tag_of(input logic [5:0] f);
        case (f)
            6'h20: return "R1/R3";
            6'h22: return "R2/R4";
            6'h24, 6'h25: return "R5/R11";
            6'h26, 6'h27: return "R6/R11";
            6'h00: return "R7/R10";
            6'h02: return "R8/R10";
            6'h03: return "R9/R10";
            default: return "R12";
        endcase
    endfunction

    task automatic push(input logic [31:0] a, input logic [31:0] b,
                        input logic [5:0] f, input logic [4:0] sh, input string tag);
        vec_t v;
        v.a = a; v.b = b; v.f = f; v.sh = sh; v.tag = tag;
        vq.push_back(v);
    endtask

    // Drive just after a rising edge, compare at the following falling edge
    task automatic run_vec(input vec_t v);
        logic [31:0] er;
        logic        eo;
        @(posedge clk);
        #0.5;
        op_a = v.a; op_b = v.b; func_code = v.f; shamt = v.sh;
        model(v.a, v.b, v.f, v.sh, er, eo);
        @(negedge clk);
        total++;
        if (result !== er || overflow !== eo) begin
            bad++;
            $display("FAIL %s f=%02h a=%08h b=%08h sh=%0d: result=%08h ovf=%b expected result=%08h ovf=%b",
                     v.tag, v.f, v.a, v.b, v.sh, result, overflow, er, eo);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        total++;
        if (result !== 32'h0 || overflow !== 1'b0) begin
            bad++;
            $display("FAIL reset/R7: result=%08h ovf=%b expected result=00000000 ovf=0", result, overflow);
        end
        rst = 1'b0;

        // R1 add, wrap
        push(32'd5, 32'd7, 6'h20, 5'd0, "R1");
        push(32'hFFFF_FFFF, 32'd1, 6'h20, 5'd0, "R1");
        // R3 add overflow
        push(32'h7FFF_FFFF, 32'd1, 6'h20, 5'd0, "R3");
        push(32'h8000_0000, 32'h8000_0000, 6'h20, 5'd0, "R3");
        push(32'h8000_0000, 32'hFFFF_FFFB, 6'h20, 5'd0, "R3");
        push(32'h7FFF_FFFF, 32'hFFFF_FFFF, 6'h20, 5'd0, "R3");
        // R2 / R4 subtract
        push(32'd10, 32'd3, 6'h22, 5'd0, "R2");
        push(32'd3, 32'd10, 6'h22, 5'd0, "R2");
        push(32'h0, 32'h8000_0000, 6'h22, 5'd0, "R4");
        push(32'h7FFF_FFFF, 32'hFFFF_FFFF, 6'h22, 5'd0, "R4");
        push(32'h8000_0000, 32'd1, 6'h22, 5'd0, "R4");
        push(32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'h22, 5'd0, "R4");
        // R5 / R6 bitwise
        push(32'h0000_03C0, 32'h0000_00D0, 6'h24, 5'd0, "R5");
        push(32'h0000_03C0, 32'h0000_00D0, 6'h25, 5'd0, "R5");
        push(32'h0000_03C0, 32'h0000_00D0, 6'h27, 5'd0, "R6");
        push(32'h0000_03C0, 32'h0000_00D0, 6'h26, 5'd0, "R6");
        push(32'h1234_5678, 32'h0, 6'h27, 5'd0, "R6");
        // R11 extreme operands on non-arithmetic ops
        push(32'h7FFF_FFFF, 32'h7FFF_FFFF, 6'h25, 5'd0, "R11");
        push(32'h8000_0000, 32'h8000_0000, 6'h26, 5'd0, "R11");
        push(32'h7FFF_FFFF, 32'h7FFF_FFFF, 6'h00, 5'd1, "R11");
        // R7 left shift, op_a has no effect
        push(32'hDEAD_BEEF, 32'd6, 6'h00, 5'd1, "R7");
        push(32'h0, 32'hFFFF_FFFF, 6'h00, 5'd31, "R7");
        // R8 right zero fill
        push(32'h0, 32'hFFFF_FFFA, 6'h02, 5'd1, "R8");
        push(32'hFFFF_FFFF, 32'h8000_0000, 6'h02, 5'd31, "R8");
        // R9 right sign fill
        push(32'h0, 32'hFFFF_FFFA, 6'h03, 5'd1, "R9");
        push(32'h0, 32'h8000_0000, 6'h03, 5'd31, "R9");
        push(32'h0, 32'h4000_0000, 6'h03, 5'd30, "R9");
        // R10 zero distance and shamt ignored elsewhere
        push(32'h0, 32'hA5A5_5A5A, 6'h00, 5'd0, "R10");
        push(32'h0, 32'hA5A5_5A5A, 6'h02, 5'd0, "R10");
        push(32'h0, 32'hA5A5_5A5A, 6'h03, 5'd0, "R10");
        push(32'd100, 32'd23, 6'h20, 5'd17, "R10");
        push(32'hF0F0_F0F0, 32'h0FF0_0FF0, 6'h24, 5'd31, "R10");
        // R12 unassigned codes
        push(32'h7FFF_FFFF, 32'd1, 6'h21, 5'd3, "R12");
        push(32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'h23, 5'd0, "R12");
        push(32'h1234_5678, 32'h9ABC_DEF0, 6'h3F, 5'd5, "R12");
        push(32'h1, 32'h8000_0000, 6'h01, 5'd4, "R12");

        for (int n = 0; n < 4000; n++) begin
            logic [5:0]  f;
            logic [31:0] a;
            logic [31:0] b;
            f = (n % 3 == 0) ? 6'($urandom_range(0, 63))
                             : 6'(n % 2 == 0 ? 6'h20 + 6'($urandom_range(0, 7))
                                             : 6'($urandom_range(0, 3)));
            a = $urandom;
            b = $urandom;
            if (n % 7 == 0) a = {a[31], {31{~a[31]}}};
            if (n % 11 == 0) b = {b[31], {31{b[30]}}};
            push(a, b, f, 5'($urandom_range(0, 31)), tag_of(f));
        end

        while (vq.size() > 0) begin
            vec_t v;
            v = vq.pop_front();
            run_vec(v);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule